// File: doc/BRIEF.md
# Idle Periodic Read Injector

This block makes sure that read traffic appears on a DRAM bus often enough for strobe-phase tracking to keep its lock as voltage and temperature drift. An interval timer counts down from a reload value. Every read that reaches the bus sends the timer back to that value. A read reaches the bus either when the controller issues one for the user (`rd_issued`) or when the arbiter accepts the dummy request. If the timer runs out during a quiet stretch, the block raises `dummy_req` toward the command arbiter. It keeps the request high until the arbiter accepts it on `dummy_ack`.

The interval is a cycle count derived from two parameters, the controller clock frequency in MHz and the period in nanoseconds. The default period is 1000 ns, which gives 400 cycles at 400 MHz. The whole function is switched off when the attached memory is DDR2 and the interface clock is at or below 200 MHz. Two static flags report that case. While the function is off, no request is made and the timer rests at its reload value.

Top module: `idle_read_injector`

## Requirements
- R1: Reset holds `dummy_req` low and loads the timer with the full interval N, where N = ceil(CLK_MHZ * PERIOD_NS / 1000) and is at least 1.
- R2: With no reads and the function enabled, `dummy_req` rises on the (N+1)th rising clock edge after the last timer reload. It stays low on every earlier edge.
- R3: Once high, `dummy_req` stays high until it is sampled together with `dummy_ack`. A user read during that time does not drop the request.
- R4: An accepted request (`dummy_req` and `dummy_ack` both high at an edge) clears `dummy_req` at that edge and reloads the timer. The next request follows N+1 edges later if the bus stays idle.
- R5: A `rd_issued` pulse reloads the timer, so reads spaced at most N edges apart never cause a request. This includes a read that arrives in the very cycle the timer reaches zero.
- R6: While `mem_is_ddr2` and `clk_le_200mhz` are both 1, `dummy_req` is low from the next edge on and the timer is held at N. After the function is re-enabled, a full N+1 edges pass before a request.
- R7: Only that flag combination disables the block. DDR2 with a fast clock (`clk_le_200mhz`=0) and non-DDR2 with a slow clock (`mem_is_ddr2`=0) both keep the injector working.
- R8: The interval follows the frequency parameter: with CLK_MHZ=20 and PERIOD_NS=1000 the interval is 20 cycles, and at 400 MHz it is 400 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_issued | input | 1 | One-cycle pulse for each read placed on the bus |
| dummy_ack | input | 1 | Arbiter accepts the pending dummy read |
| mem_is_ddr2 | input | 1 | Attached memory is DDR2 |
| clk_le_200mhz | input | 1 | Interface clock is at or below 200 MHz |
| dummy_req | output | 1 | Dummy read request toward the arbiter |

## Verification
The assertions assume that `dummy_ack` is only meaningful while `dummy_req` is high. They also assume that the two mode flags change only between whole cycles and are treated as quasi-static. The bench drives every input on the falling edge and raises `dummy_ack` only after it has seen the request high. It pulses `rd_issued` for exactly one cycle, so each stimulus stays inside the handshake the arbiter would produce. Flag changes are also made on a falling edge, with the request either pending or idle, so both the drop-on-disable case and the frozen-timer case are reached.

// File: rtl/iri_pkg.sv
package iri_pkg;

  // Ceiling division of (MHz * ns) / 1000, never below one cycle.
  function automatic int unsigned interval_cycles(input int unsigned mhz,
                                                  input int unsigned ns);
    int unsigned prod;
    int unsigned cyc;
    prod = mhz * ns;
    cyc  = (prod + 999) / 1000;
    return (cyc == 0) ? 1 : cyc;
  endfunction

  // Bits needed to hold the value n.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Returns 1 when the memory/speed combination turns the injector off.
  function automatic logic mode_blocks(input logic ddr2, input logic slow);
    return ddr2 & slow;
  endfunction

endpackage

// File: rtl/iri_mode_gate.sv
module iri_mode_gate (
  input  logic mem_is_ddr2,
  input  logic clk_le_200mhz,
  output logic enable_o
);
  import iri_pkg::*;

  always_comb enable_o = ~mode_blocks(mem_is_ddr2, clk_le_200mhz);

  always_comb begin
    assert_gate_combo_R7: assert (enable_o == ~(mem_is_ddr2 && clk_le_200mhz));
  end
endmodule

// File: rtl/iri_interval_timer.sv
module iri_interval_timer #(
  parameter int unsigned INTERVAL = 400,
  parameter int unsigned CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          reload,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  localparam logic [CW-1:0] LOAD = CW'(INTERVAL);

  logic [CW-1:0] cnt_q;
  logic          at_zero;

  always_comb at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= LOAD;
    else if (!enable || reload)
      cnt_q <= LOAD;
    else if (!at_zero)
      cnt_q <= cnt_q - 1'b1;
  end

  // A reload in the same cycle suppresses the expiry.
  always_comb expired_o = enable && at_zero && !reload;
  always_comb cnt_o     = cnt_q;

  assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reload) |=> (cnt_q == LOAD));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == LOAD));

  assert_rest_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && at_zero && !reload) |=> at_zero);
endmodule

// File: rtl/iri_request_hold.sv
module iri_request_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic expired,
  input  logic ack,
  output logic req_o,
  output logic accepted_o
);
  logic req_q;

  always_comb accepted_o = req_q && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else if (!enable)
      req_q <= 1'b0;
    else if (accepted_o)
      req_q <= 1'b0;
    else if (expired)
      req_q <= 1'b1;
  end

  always_comb req_o = req_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack && enable) |=> req_q);

  assert_drop_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accepted_o |=> !req_q);

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req_q);
endmodule

// File: rtl/idle_read_injector.sv
module idle_read_injector #(
  parameter int unsigned CLK_MHZ   = 400,
  parameter int unsigned PERIOD_NS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issued,
  input  logic dummy_ack,
  input  logic mem_is_ddr2,
  input  logic clk_le_200mhz,
  output logic dummy_req
);
  import iri_pkg::*;

  localparam int unsigned INTERVAL = interval_cycles(CLK_MHZ, PERIOD_NS);
  localparam int unsigned CW       = count_width(INTERVAL);

  logic          inj_enable;
  logic          tmr_expired;
  logic          req_accepted;
  logic          tmr_reload;
  logic [CW-1:0] tmr_cnt;

  iri_mode_gate u_gate (
    .mem_is_ddr2  (mem_is_ddr2),
    .clk_le_200mhz(clk_le_200mhz),
    .enable_o     (inj_enable)
  );

  // Every read that reaches the bus, user or dummy, restarts the interval.
  always_comb tmr_reload = rd_issued || req_accepted;

  iri_interval_timer #(.INTERVAL(INTERVAL), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (inj_enable),
    .reload   (tmr_reload),
    .cnt_o    (tmr_cnt),
    .expired_o(tmr_expired)
  );

  iri_request_hold u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (inj_enable),
    .expired   (tmr_expired),
    .ack       (dummy_ack),
    .req_o     (dummy_req),
    .accepted_o(req_accepted)
  );

  assert_rise_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_req) |-> $past(tmr_expired));

  assert_accept_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accepted && inj_enable) |=> (tmr_cnt == CW'(INTERVAL) && !dummy_req));

  initial begin
    assert_interval_nonzero_R8: assert (INTERVAL >= 1);
  end
endmodule

// File: tb/sim_idle_read_injector.sv
module sim_idle_read_injector;
  localparam int unsigned MHZ = 20;
  localparam int unsigned NS  = 1000;
  localparam int N = (MHZ * NS) / 1000; // exact here: 20 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_issued = 1'b0;
  logic dummy_ack = 1'b0;
  logic mem_is_ddr2 = 1'b0;
  logic clk_le_200mhz = 1'b0;
  logic dummy_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  idle_read_injector #(.CLK_MHZ(MHZ), .PERIOD_NS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_issued(rd_issued), .dummy_ack(dummy_ack),
    .mem_is_ddr2(mem_is_ddr2), .clk_le_200mhz(clk_le_200mhz),
    .dummy_req(dummy_req)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_to_req(output int k);
    k = 0;
    do begin
      step();
      k++;
    end while (!dummy_req && k < 10 * N);
  endtask

  task automatic accept();
    dummy_ack = 1'b1;
    step();
    dummy_ack = 1'b0;
  endtask

  task automatic pulse_read();
    rd_issued = 1'b1;
    step();
    rd_issued = 1'b0;
  endtask

  task automatic t_reset();
    int k;
    rst_n = 1'b0;
    repeat (3) step();
    check(dummy_req == 1'b0, "R1", dummy_req, 0);
    rst_n = 1'b1;
    count_to_req(k);
    check(k == N + 1, "R1", k, N + 1);
    check(k == N + 1, "R8", k, MHZ + 1);
  endtask

  task automatic t_hold();
    bit stayed = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      if (!dummy_req) stayed = 1'b0;
    end
    check(stayed, "R3", stayed, 1);
    pulse_read();
    check(dummy_req == 1'b1, "R3", dummy_req, 1);
  endtask

  task automatic t_accept();
    int k;
    accept();
    check(dummy_req == 1'b0, "R4", dummy_req, 0);
    count_to_req(k);
    check(k == N + 1, "R4", k, N + 1);
  endtask

  task automatic t_natural();
    bit quiet = 1'b1;
    accept();
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N - 1; i++) begin
        step();
        if (dummy_req) quiet = 1'b0;
      end
      pulse_read();
      if (dummy_req) quiet = 1'b0;
    end
    check(quiet, "R5", quiet, 1);
  endtask

  task automatic t_late_read();
    int k;
    pulse_read();
    repeat (N) step();
    check(dummy_req == 1'b0, "R2", dummy_req, 0);
    pulse_read();
    check(dummy_req == 1'b0, "R5", dummy_req, 0);
    count_to_req(k);
    check(k == N + 1, "R5", k, N + 1);
  endtask

  task automatic t_disable();
    int k;
    bit quiet = 1'b1;
    mem_is_ddr2 = 1'b1;
    clk_le_200mhz = 1'b1;
    step();
    check(dummy_req == 1'b0, "R6", dummy_req, 0);
    for (int i = 0; i < 3 * N; i++) begin
      step();
      if (dummy_req) quiet = 1'b0;
    end
    check(quiet, "R6", quiet, 1);
    clk_le_200mhz = 1'b0; // DDR2, fast clock: active
    count_to_req(k);
    check(k == N + 1, "R7", k, N + 1);
    accept();
    repeat (N / 2) step();
    clk_le_200mhz = 1'b1; // off mid-count: timer must freeze at full
    repeat (2 * N) step();
    mem_is_ddr2 = 1'b0;   // non-DDR2, slow clock: active
    count_to_req(k);
    check(k == N + 1, "R6", k, N + 1);
    check(k == N + 1, "R7", k, N + 1);
    accept();
    clk_le_200mhz = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_accept();
    t_natural();
    t_late_read();
    t_disable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule